// File: doc/BRIEF.md
# Dual-Polarization Channel Power Integrator

This block sits after a channelizer. It measures the power in every frequency channel of two polarizations and integrates that power over a programmable number of whole spectra. Channel samples arrive one per cycle when `valid_i` is high. `frame_start_i` marks channel 0 of each spectrum. Each polarization travels on its own 48-bit bus that carries the real and imaginary parts together.

For each sample the block forms the squared magnitude and drops low-order bits to make headroom. It then adds the result into a 64-bit running sum kept for that channel and polarization. A pulse on `sync_i` abandons any partial integration, and a new one begins at the next frame start.

When the programmed number of spectra have been summed, the finished totals are moved into the free half of a two-bank result store and the banks swap. The host therefore always reads one complete integration. An integration counter steps on every swap, so software can tell when fresh results are ready. A registered read port returns both polarizations' sums for one channel.

Top module: `chan_power_integrator`

## Requirements
- R1: Each input bus carries the real part in bits [47:24] and the imaginary part in bits [23:0], both two's complement with 23 fractional bits. The power is re²+im² as an unsigned 42-bit value with 40 fractional bits. The six lowest bits of that value are discarded before accumulation, so each sample contributes (re²+im²) >> 12 in raw integer units.
- R2: Every channel of every polarization keeps an independent 64-bit unsigned sum of its contributions over one integration. The host reads the sums as unsigned 64-bit integers.
- R3: After reset or a `sync_i` pulse, samples are ignored until a valid sample with `frame_start_i` high arrives, and integration starts with that sample. A sync in mid-integration discards the partial sums, and no dump results from them.
- R4: The sample that carries `frame_start_i` is channel 0. Each further valid sample advances the channel by one, and cycles with `valid_i` low are skipped. Samples beyond channel NCHAN-1 are ignored until the next frame start.
- R5: `acc_len_i` is captured when an integration starts and gives its length in whole spectra. A value of 0 is treated as 1. Changes during an integration apply only to the next one.
- R6: When the last channel of the last spectrum is accepted, the finished sums become readable, the banks swap and `int_count_o` increments by one. All of this is visible on the second rising edge after that sample is presented. Until then, reads return the previous integration.
- R7: The read port is registered: `rd_pol0_o` and `rd_pol1_o` show the sums for `rd_addr_i` one cycle after the address is applied.
- R8: Integrations run back to back without a new sync. Each begins with fresh sums at the frame start that follows the end of the previous one.
- R9: After reset `int_count_o` is 0 and every readable sum is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Abandon the current integration and rearm at the next frame start |
| valid_i | input | 1 | Channel sample present this cycle |
| frame_start_i | input | 1 | This sample is channel 0 of a spectrum |
| pol0_i | input | 48 | Polarization 0 sample, real in [47:24], imaginary in [23:0] |
| pol1_i | input | 48 | Polarization 1 sample, same layout |
| acc_len_i | input | ALENW | Integration length in spectra |
| rd_addr_i | input | $clog2(NCHAN) | Channel to read |
| rd_pol0_o | output | 64 | Integrated power of polarization 0 for the addressed channel |
| rd_pol1_o | output | 64 | Integrated power of polarization 1 for the addressed channel |
| int_count_o | output | CNTW | Number of completed integrations |

## Verification
The assertions take for granted that the upstream channelizer delivers each spectrum as exactly NCHAN valid samples before the next frame start. They also assume the integration length keeps the 64-bit sums from wrapping. The read-stability check further assumes that the host holds its address steady while it expects an unchanged result. The stimulus delivers full spectra, except where the bench deliberately appends surplus samples that the block must drop. It keeps integration lengths in single digits, so even full-scale samples stay far from the sum's limit. Its reads hold each address for two cycles.

// File: rtl/cpi_pkg.sv
package cpi_pkg;

    // Sample layout: two signed components packed on one bus.
    localparam int COMP_W    = 24;
    localparam int BUS_W     = 2 * COMP_W;

    // Power after squaring: unsigned, 40 fractional bits.
    localparam int PWR_W     = 42;
    localparam int RAW_SQ_W  = 2 * COMP_W;            // re^2 + im^2 at full precision
    localparam int RAW_SHIFT = RAW_SQ_W - PWR_W;      // raw -> 42-bit power
    localparam int DROP_LSB  = 6;                     // bits dropped before summing
    localparam int CONTRIB_W = PWR_W - DROP_LSB;

    localparam int SUM_W     = 64;
    localparam int NPOL      = 2;

    typedef enum logic [0:0] {
        SEQ_WAIT = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_e;

endpackage

// File: rtl/cpi_power_sq.sv
module cpi_power_sq
    import cpi_pkg::*;
(
    input  logic [BUS_W-1:0]     bus_i,
    output logic [CONTRIB_W-1:0] contrib_o
);

    logic signed [COMP_W-1:0] re_s;
    logic signed [COMP_W-1:0] im_s;
    logic [RAW_SQ_W-1:0]      re_sq;
    logic [RAW_SQ_W-1:0]      im_sq;
    logic [RAW_SQ_W-1:0]      raw_sum;
    logic [PWR_W-1:0]         power;

    assign re_s    = bus_i[BUS_W-1:COMP_W];
    assign im_s    = bus_i[COMP_W-1:0];

    // Squares of signed values are non-negative; the full width holds them.
    assign re_sq   = RAW_SQ_W'(re_s * re_s);
    assign im_sq   = RAW_SQ_W'(im_s * im_s);
    assign raw_sum = re_sq + im_sq;

    assign power     = PWR_W'(raw_sum >> RAW_SHIFT);
    assign contrib_o = CONTRIB_W'(power >> DROP_LSB);

    // R1: the squared magnitude of two Q1.23 values never exceeds 2.0
    always_comb begin
        p_power_bound_r1: assert (power <= (PWR_W'(1) << (PWR_W - 1)))
            else $error("power value above full scale");
    end

endmodule

// File: rtl/cpi_chan_store.sv
module cpi_chan_store
    import cpi_pkg::*;
#(
    parameter int NCHAN = 256,
    localparam int CHW  = $clog2(NCHAN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [CHW-1:0]       wr_ch_i,
    input  logic                 wr_first_i,
    input  logic                 wr_last_i,
    input  logic [CONTRIB_W-1:0] wr_pow_i,
    input  logic                 rbank_i,
    input  logic [CHW-1:0]       rd_addr_i,
    output logic [SUM_W-1:0]     rd_data_o
);

    typedef struct packed {
        logic [NCHAN-1:0][SUM_W-1:0]      acc;
        logic [1:0][NCHAN-1:0][SUM_W-1:0] bank;
        logic [SUM_W-1:0]                 rd;
    } store_t;

    store_t st_d, st_q;
    logic [SUM_W-1:0] base_val;
    logic [SUM_W-1:0] sum_new;

    // First spectrum of an integration overwrites, so no bulk clear is needed.
    assign base_val = wr_first_i ? '0 : st_q.acc[wr_ch_i];
    assign sum_new  = base_val + SUM_W'(wr_pow_i);

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.acc[wr_ch_i] = sum_new;
            if (wr_last_i) begin
                st_d.bank[~rbank_i][wr_ch_i] = sum_new;
            end
        end
        st_d.rd = st_q.bank[rbank_i][rd_addr_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.rd;

    // R2: a running sum must never wrap inside its 64 bits
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_first_i) |-> (sum_new >= st_q.acc[wr_ch_i]))
        else $error("channel sum wrapped");

    // R7: same address and same readable bank give the same data back
    p_rd_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_addr_i) && $stable(rbank_i)) |=> $stable(rd_data_o))
        else $error("readable bank changed under a held address");

endmodule

// File: rtl/chan_power_integrator.sv
module chan_power_integrator
    import cpi_pkg::*;
#(
    parameter int NCHAN = 256,
    parameter int ALENW = 32,
    parameter int CNTW  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sync_i,
    input  logic                     valid_i,
    input  logic                     frame_start_i,
    input  logic [BUS_W-1:0]         pol0_i,
    input  logic [BUS_W-1:0]         pol1_i,
    input  logic [ALENW-1:0]         acc_len_i,
    input  logic [$clog2(NCHAN)-1:0] rd_addr_i,
    output logic [SUM_W-1:0]         rd_pol0_o,
    output logic [SUM_W-1:0]         rd_pol1_o,
    output logic [CNTW-1:0]          int_count_o
);

    localparam int CHW = $clog2(NCHAN);

    typedef struct packed {
        seq_e                           state;
        logic [CHW:0]                   ch;      // next channel, saturates at NCHAN
        logic [ALENW-1:0]               spec;    // spectrum index inside the integration
        logic [ALENW-1:0]               len;     // captured integration length
        logic                           rbank;   // bank the host reads
        logic [CNTW-1:0]                icount;
        logic                           s1_vld;
        logic [CHW-1:0]                 s1_ch;
        logic                           s1_first;
        logic                           s1_last;
        logic                           s1_end;
        logic [NPOL-1:0][CONTRIB_W-1:0] s1_pow;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NPOL-1:0][BUS_W-1:0]     pol_bus;
    logic [NPOL-1:0][CONTRIB_W-1:0] pol_pow;
    logic [NPOL-1:0][SUM_W-1:0]     pol_rd;
    logic [ALENW-1:0]               len_eff;

    assign pol_bus[0] = pol0_i;
    assign pol_bus[1] = pol1_i;
    assign len_eff    = (acc_len_i == '0) ? ALENW'(1) : acc_len_i;

    for (genvar p = 0; p < NPOL; p++) begin : g_pol
        cpi_power_sq u_pwr (
            .bus_i     (pol_bus[p]),
            .contrib_o (pol_pow[p])
        );

        cpi_chan_store #(.NCHAN(NCHAN)) u_store (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en_i    (ctl_q.s1_vld),
            .wr_ch_i    (ctl_q.s1_ch),
            .wr_first_i (ctl_q.s1_first),
            .wr_last_i  (ctl_q.s1_last),
            .wr_pow_i   (ctl_q.s1_pow[p]),
            .rbank_i    (ctl_q.rbank),
            .rd_addr_i  (rd_addr_i),
            .rd_data_o  (pol_rd[p])
        );
    end

    always_comb begin
        logic             take;
        logic [CHW-1:0]   ch_use;
        logic [ALENW-1:0] spec_use;
        logic [ALENW-1:0] len_use;

        ctl_d    = ctl_q;
        take     = 1'b0;
        ch_use   = '0;
        spec_use = ctl_q.spec;
        len_use  = ctl_q.len;

        // Completion of the sample written this edge swaps the banks.
        if (ctl_q.s1_vld && ctl_q.s1_end) begin
            ctl_d.rbank  = ~ctl_q.rbank;
            ctl_d.icount = ctl_q.icount + CNTW'(1);
        end

        if (sync_i) begin
            ctl_d.state = SEQ_WAIT;
        end else if (valid_i) begin
            if (frame_start_i) begin
                take   = 1'b1;
                ch_use = '0;
                if (ctl_q.state == SEQ_WAIT ||
                    ctl_q.spec == ctl_q.len - ALENW'(1)) begin
                    spec_use = '0;
                    len_use  = len_eff;
                end else begin
                    spec_use = ctl_q.spec + ALENW'(1);
                end
                ctl_d.state = SEQ_RUN;
                ctl_d.ch    = (CHW+1)'(1);
                ctl_d.spec  = spec_use;
                ctl_d.len   = len_use;
            end else if (ctl_q.state == SEQ_RUN && ctl_q.ch < (CHW+1)'(NCHAN)) begin
                take     = 1'b1;
                ch_use   = CHW'(ctl_q.ch);
                ctl_d.ch = ctl_q.ch + (CHW+1)'(1);
            end
        end

        ctl_d.s1_vld   = take;
        ctl_d.s1_ch    = ch_use;
        ctl_d.s1_first = (spec_use == '0);
        ctl_d.s1_last  = (spec_use == len_use - ALENW'(1));
        ctl_d.s1_end   = ctl_d.s1_last && (ch_use == CHW'(NCHAN - 1));
        ctl_d.s1_pow   = pol_pow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= SEQ_WAIT;
            ctl_q.len   <= ALENW'(1);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_pol0_o   = pol_rd[0];
    assign rd_pol1_o   = pol_rd[1];
    assign int_count_o = ctl_q.icount;

    // R6: the integration counter only ever advances by one
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_count_o != $past(int_count_o)) |-> (int_count_o == $past(int_count_o) + CNTW'(1)))
        else $error("integration counter jumped");

    // R3: while rearmed, nothing without a frame start enters the pipeline
    p_wait_ignores_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == SEQ_WAIT && !(valid_i && frame_start_i)) |=> !ctl_q.s1_vld)
        else $error("sample accepted before frame start");

    // R3: the sample presented with a sync is dropped
    p_sync_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> !ctl_q.s1_vld)
        else $error("sample accepted during sync");

    // R5: a running integration never has zero length
    p_len_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == SEQ_RUN) |-> (ctl_q.len != '0))
        else $error("zero integration length captured");

endmodule

// File: tb/chan_power_integrator_tb.sv
module chan_power_integrator_tb;

    localparam int NCH = 4;
    localparam int AW  = $clog2(NCH);

    // Vector table: integration length, base value, channel step, expected dumps.
    localparam int NVEC = 4;
    localparam int VEC [NVEC][4] = '{
        '{1, 1000,    37,    1},
        '{3, -200000, 4099,  1},
        '{2, 8388607, -1,    1},
        '{5, 123456,  77777, 1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_i = 1'b0;
    logic          valid_i = 1'b0;
    logic          frame_start_i = 1'b0;
    logic [47:0]   pol0_i = '0;
    logic [47:0]   pol1_i = '0;
    logic [31:0]   acc_len_i = 32'd1;
    logic [AW-1:0] rd_addr_i = '0;
    logic [63:0]   rd_pol0_o;
    logic [63:0]   rd_pol1_o;
    logic [31:0]   int_count_o;

    int checks = 0;
    int failures = 0;
    longint unsigned cur0 [NCH];
    longint unsigned cur1 [NCH];
    longint unsigned exp0 [NCH];
    longint unsigned exp1 [NCH];

    always #2.5 clk = ~clk;

    chan_power_integrator #(.NCHAN(NCH)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_i        (sync_i),
        .valid_i       (valid_i),
        .frame_start_i (frame_start_i),
        .pol0_i        (pol0_i),
        .pol1_i        (pol1_i),
        .acc_len_i     (acc_len_i),
        .rd_addr_i     (rd_addr_i),
        .rd_pol0_o     (rd_pol0_o),
        .rd_pol1_o     (rd_pol1_o),
        .int_count_o   (int_count_o)
    );

    task automatic chk(bit ok, string req, longint unsigned act, longint unsigned expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, expv);
        end
    endtask

    function automatic logic [47:0] mk(int re, int im);
        return {re[23:0], im[23:0]};
    endfunction

    // Contribution per R1: (re^2 + im^2) >> 12
    function automatic longint unsigned pw(logic [47:0] b);
        longint r = longint'($signed(b[47:24]));
        longint i = longint'($signed(b[23:0]));
        return longint'(unsigned'((r * r + i * i) >>> 12));
    endfunction

    task automatic drive(bit fs, logic [47:0] b0, logic [47:0] b1);
        @(negedge clk);
        valid_i = 1'b1; frame_start_i = fs; pol0_i = b0; pol1_i = b1;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            valid_i = 1'b0; frame_start_i = 1'b0;
        end
    endtask

    task automatic pulse_sync();
        @(negedge clk);
        valid_i = 1'b0; frame_start_i = 1'b0; sync_i = 1'b1;
        @(negedge clk);
        sync_i = 1'b0;
    endtask

    task automatic spectrum(int s, int base, int step, bit first, int extra, bit gaps);
        for (int c = 0; c < NCH; c++) begin
            logic [47:0] b0 = mk(base + step * c + 5 * s, -base + 3 * c - 2 * s);
            logic [47:0] b1 = mk(base - step * c + 11, base * 3 + c * s);
            if (gaps && c != 0) idle(1);
            drive(c == 0, b0, b1);
            cur0[c] = (first ? 64'd0 : cur0[c]) + pw(b0);
            cur1[c] = (first ? 64'd0 : cur1[c]) + pw(b1);
        end
        for (int e = 0; e < extra; e++) drive(1'b0, mk(-8388608, 8388607), mk(8388607, -8388608));
    endtask

    task automatic commit();
        for (int c = 0; c < NCH; c++) begin
            exp0[c] = cur0[c];
            exp1[c] = cur1[c];
        end
    endtask

    task automatic integrate(int len, int base, int step);
        for (int s = 0; s < len; s++) spectrum(s, base, step, s == 0, 0, 1'b0);
        commit();
    endtask

    task automatic read_all(string req);
        for (int c = 0; c < NCH; c++) begin
            @(negedge clk);
            rd_addr_i = AW'(c);
            @(negedge clk);
            chk(rd_pol0_o == exp0[c], req, rd_pol0_o, exp0[c]);
            chk(rd_pol1_o == exp1[c], req, rd_pol1_o, exp1[c]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog expired act=%0d exp=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int c0;
        for (int c = 0; c < NCH; c++) begin exp0[c] = 0; exp1[c] = 0; end

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        chk(int_count_o == 0, "R9 count after reset", int_count_o, 0);
        read_all("R9 zero sums after reset");

        // R3: samples before the first frame start are ignored
        drive(1'b0, mk(5000, 5000), mk(6000, 6000));
        drive(1'b0, mk(7000, 7000), mk(8000, 8000));
        idle(1);

        // Vector table walk (R1, R2, R6)
        for (int v = 0; v < NVEC; v++) begin
            acc_len_i = VEC[v][0];
            pulse_sync();
            c0 = int_count_o;
            integrate(VEC[v][0], VEC[v][1], VEC[v][2]);
            idle(1);
            chk(int_count_o == c0, "R6 no dump before second edge", int_count_o, c0);
            idle(1);
            chk(int_count_o == c0 + VEC[v][3], "R6 dump count", int_count_o, c0 + VEC[v][3]);
            read_all("R1 R2 vector sums");
        end

        // R3: sync in mid-integration discards partial sums
        acc_len_i = 2;
        pulse_sync();
        c0 = int_count_o;
        spectrum(0, 999, 5, 1'b1, 0, 1'b0);
        pulse_sync();
        integrate(2, 55, 66);
        idle(2);
        chk(int_count_o == c0 + 1, "R3 sync drops partial", int_count_o, c0 + 1);
        read_all("R3 fresh sums after sync");

        // R5: length captured at start; R6: reads show the old integration meanwhile
        acc_len_i = 3;
        pulse_sync();
        c0 = int_count_o;
        spectrum(0, 4321, 9, 1'b1, 0, 1'b0);
        acc_len_i = 1;
        spectrum(1, 4321, 9, 1'b0, 0, 1'b0);
        idle(2);
        chk(int_count_o == c0, "R5 length held mid-integration", int_count_o, c0);
        read_all("R6 previous integration readable");
        spectrum(2, 4321, 9, 1'b0, 0, 1'b0);
        commit();
        idle(2);
        chk(int_count_o == c0 + 1, "R5 three spectra summed", int_count_o, c0 + 1);
        read_all("R5 sums of three spectra");

        // R5: length 0 behaves as 1
        acc_len_i = 0;
        pulse_sync();
        c0 = int_count_o;
        integrate(1, -77777, 300);
        idle(2);
        chk(int_count_o == c0 + 1, "R5 zero length as one", int_count_o, c0 + 1);
        read_all("R5 zero length sums");

        // R4: surplus samples and valid gaps
        acc_len_i = 2;
        pulse_sync();
        c0 = int_count_o;
        spectrum(0, 31337, -211, 1'b1, 2, 1'b1);
        spectrum(1, 31337, -211, 1'b0, 3, 1'b0);
        commit();
        idle(2);
        chk(int_count_o == c0 + 1, "R4 surplus ignored count", int_count_o, c0 + 1);
        read_all("R4 surplus and gaps sums");

        // R8: back-to-back integrations without sync
        acc_len_i = 2;
        pulse_sync();
        c0 = int_count_o;
        integrate(2, 100000, 13);
        integrate(2, -50000, 1001);
        idle(2);
        chk(int_count_o == c0 + 2, "R8 two dumps", int_count_o, c0 + 2);
        read_all("R8 second integration sums");

        // R1 R2: full-scale negative samples, three spectra
        acc_len_i = 3;
        pulse_sync();
        c0 = int_count_o;
        for (int s = 0; s < 3; s++)
            for (int c = 0; c < NCH; c++)
                drive(c == 0, mk(-8388608, -8388608), mk(-8388608, 0));
        for (int c = 0; c < NCH; c++) begin
            exp0[c] = 3 * (64'd1 << 35);
            exp1[c] = 3 * (64'd1 << 34);
        end
        idle(2);
        chk(int_count_o == c0 + 1, "R2 full-scale dump", int_count_o, c0 + 1);
        read_all("R1 full-scale sums");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule